// File: doc/BRIEF.md
# Real-to-Absolute Prefixing with Reference/Change Key Tracking

This block sits behind an address translator in a CPU's memory path. It takes a real address, the access kind (load, store or instruction fetch) and the write permission granted so far. It turns the real address into an absolute address with the CPU's prefix value: the lowest 8 KiB of real storage and the 8 KiB area at the prefix trade places, and every other address passes through unchanged.

For each absolute page inside installed storage, the block keeps a reference bit and a change bit in a small key array. Each access sets the reference bit, and a store also sets the change bit. A load or fetch to a page whose change bit is still clear comes back without write permission. A cached translation then cannot absorb the first store silently: that store has to come back through this block, which marks the page changed. Pages at or beyond installed storage are not tracked.

The key update is a two-cycle read-modify-write. A new request may be issued every cycle, and a request to the page that the previous request is still writing sees the pending key value.

Top module: `skPrefixKeyUnit`

## Requirements
- R1: A real address below 0x2000 maps to the prefix plus that address. The prefix is taken with its low 13 bits treated as zero.
- R2: A real address whose bits above bit 12 equal those of the prefix (the range from prefix to prefix+0x1FFF) maps to the address minus the prefix, which is its low 13 bits.
- R3: Any other real address is returned unchanged as the absolute address.
- R4: A request sampled on a rising edge with `reqValid` high produces `rspValid` high, with its results, after the second rising edge that follows. With no request, `rspValid` stays low.
- R5: For a load (`reqKind` 2'b00) or a fetch (`reqKind` 2'b10) to a tracked page whose change bit is clear, `rspWriteOk` is 0. Otherwise `rspWriteOk` equals `reqWriteOk`.
- R6: A store (`reqKind` 2'b01) to a tracked page returns `rspWriteOk` equal to `reqWriteOk` and sets that page's change bit.
- R7: Every access to a tracked page sets its reference bit. `rspPrevRef` and `rspPrevChg` report the page's bits as they were before that access.
- R8: An absolute address at or above NUM_PAGES*4096 (0x40000 by default) updates no key and reports 0 in both previous-bit outputs. `rspWriteOk` equals `reqWriteOk`.
- R9: Requests in consecutive cycles to the same page each see the key as left by the request before them.
- R10: Reset clears every reference and change bit and drives `rspValid` low.
- R11: The low 13 bits of `prefix` have no effect on the mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqAddr | input | ADDR_W | Real address |
| reqKind | input | 2 | 00 load, 01 store, 10 fetch |
| reqWriteOk | input | 1 | Write permission granted so far |
| prefix | input | ADDR_W | Prefix value (low 13 bits ignored) |
| rspValid | output | 1 | Response present |
| rspAbsAddr | output | ADDR_W | Absolute address |
| rspWriteOk | output | 1 | Adjusted write permission |
| rspPrevRef | output | 1 | Reference bit before this access |
| rspPrevChg | output | 1 | Change bit before this access |

## Verification
Every response comes out two rising edges after its request. The bench drives each request just after a falling edge and reads the response at the falling edge two clock periods later, between the edges at which the outputs change. Vector-table requests are separated by idle cycles, so each key read-modify-write is written back before the next request. The forwarding test issues requests on adjacent cycles and checks the responses on adjacent falling edges. The key contents are observed only through the previous-bit outputs of later accesses.

// File: rtl/skPkg.sv
package skPkg;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'b00,
    ACC_STORE = 2'b01,
    ACC_FETCH = 2'b10
  } accKind_e;

  typedef struct packed {
    logic refBit;
    logic chgBit;
  } pageKey_t;

  typedef struct packed {
    logic captureReq;
    logic captureRsp;
    logic commitKey;
  } stageStrobe_t;

endpackage

// File: rtl/skPrefixMap.sv
module skPrefixMap #(
  parameter int ADDR_W    = 32,
  parameter int SWAP_BITS = 13
) (
  input  logic [ADDR_W-1:0] realAddr,
  input  logic [ADDR_W-1:0] prefix,
  output logic [ADDR_W-1:0] absAddr
);
  localparam int HI_W = ADDR_W - SWAP_BITS;

  logic [HI_W-1:0]      realHi;
  logic [HI_W-1:0]      pfxHi;
  logic [SWAP_BITS-1:0] realLo;
  logic                 lowHit;
  logic                 pfxHit;

  assign realHi = realAddr[ADDR_W-1:SWAP_BITS];
  assign realLo = realAddr[SWAP_BITS-1:0];
  assign pfxHi  = prefix[ADDR_W-1:SWAP_BITS];
  assign lowHit = (realHi == '0);
  assign pfxHit = (realHi == pfxHi);

  always_comb begin
    if (lowHit)      absAddr = {pfxHi, realLo};
    else if (pfxHit) absAddr = {{HI_W{1'b0}}, realLo};
    else             absAddr = realAddr;
  end

  always_comb begin
    // R1
    if (lowHit) low_to_prefix_chk: assert (absAddr[ADDR_W-1:SWAP_BITS] == pfxHi);
    // R2
    if (!lowHit && pfxHit) prefix_to_low_chk: assert (absAddr[ADDR_W-1:SWAP_BITS] == '0);
  end
endmodule

// File: rtl/skKeyArray.sv
module skKeyArray
  import skPkg::*;
#(
  parameter int NUM_PAGES = 64,
  localparam int IDX_W    = $clog2(NUM_PAGES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IDX_W-1:0] rdIdx,
  output pageKey_t         rdKey,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  pageKey_t         wrKey
);
  pageKey_t keyMem [NUM_PAGES];

  for (genvar g = 0; g < NUM_PAGES; g++) begin : gKey
    always_ff @(posedge clk) begin
      if (!rstN)                                 keyMem[g] <= '0;
      else if (wrEn && wrIdx == IDX_W'(g))       keyMem[g] <= wrKey;
    end
  end

  assign rdKey = keyMem[rdIdx];

  // R7
  ref_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> keyMem[$past(wrIdx)].refBit);

  // R6
  chg_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && keyMem[wrIdx].chgBit) |=> keyMem[$past(wrIdx)].chgBit);
endmodule

// File: rtl/skDatapath.sv
module skDatapath
  import skPkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  parameter int NUM_PAGES = 64,
  parameter int SWAP_BITS = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  stageStrobe_t      strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqKind,
  input  logic              reqWriteOk,
  input  logic [ADDR_W-1:0] prefix,
  output logic [ADDR_W-1:0] rspAbsAddr,
  output logic              rspWriteOk,
  output logic              rspPrevRef,
  output logic              rspPrevChg
);
  localparam int IDX_W = $clog2(NUM_PAGES);
  localparam logic [ADDR_W:0] MEM_BYTES = (ADDR_W+1)'(NUM_PAGES) << PAGE_BITS;

  logic [ADDR_W-1:0] mappedAddr;

  logic [ADDR_W-1:0] s1Abs;
  accKind_e          s1Kind;
  logic              s1WriteOk;
  logic              s1InRange;
  logic [IDX_W-1:0]  s1Page;

  logic              wrInRange;
  logic [IDX_W-1:0]  wrPage;
  pageKey_t          wrKey;

  pageKey_t          memKey;
  pageKey_t          curKey;
  pageKey_t          nextKey;
  logic              s1IsStore;
  logic              outWriteOk;

  skPrefixMap #(.ADDR_W(ADDR_W), .SWAP_BITS(SWAP_BITS)) uMap (
    .realAddr(reqAddr),
    .prefix  (prefix),
    .absAddr (mappedAddr)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Abs     <= '0;
      s1Kind    <= ACC_LOAD;
      s1WriteOk <= 1'b0;
      s1InRange <= 1'b0;
      s1Page    <= '0;
    end else if (strobe.captureReq) begin
      s1Abs     <= mappedAddr;
      s1Kind    <= accKind_e'(reqKind);
      s1WriteOk <= reqWriteOk;
      s1InRange <= ({1'b0, mappedAddr} < MEM_BYTES);
      s1Page    <= mappedAddr[PAGE_BITS +: IDX_W];
    end
  end

  skKeyArray #(.NUM_PAGES(NUM_PAGES)) uKeys (
    .clk  (clk),
    .rstN (rstN),
    .rdIdx(s1Page),
    .rdKey(memKey),
    .wrEn (strobe.commitKey && wrInRange),
    .wrIdx(wrPage),
    .wrKey(wrKey)
  );

  assign curKey    = (strobe.commitKey && wrInRange && wrPage == s1Page) ? wrKey : memKey;
  assign s1IsStore = (s1Kind == ACC_STORE);
  assign nextKey   = '{refBit: 1'b1, chgBit: curKey.chgBit | s1IsStore};
  assign outWriteOk = s1WriteOk && !(s1InRange && !s1IsStore && !curKey.chgBit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspAbsAddr <= '0;
      rspWriteOk <= 1'b0;
      rspPrevRef <= 1'b0;
      rspPrevChg <= 1'b0;
      wrInRange  <= 1'b0;
      wrPage     <= '0;
      wrKey      <= '0;
    end else if (strobe.captureRsp) begin
      rspAbsAddr <= s1Abs;
      rspWriteOk <= outWriteOk;
      rspPrevRef <= s1InRange && curKey.refBit;
      rspPrevChg <= s1InRange && curKey.chgBit;
      wrInRange  <= s1InRange;
      wrPage     <= s1Page;
      wrKey      <= nextKey;
    end
  end

  // R8
  untracked_no_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.captureRsp && !s1InRange) |=> (!rspPrevRef && !rspPrevChg));
endmodule

// File: rtl/skControl.sv
module skControl
  import skPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  output stageStrobe_t strobe,
  output logic         rspValid
);
  logic s1Valid;
  logic s2Valid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Valid <= 1'b0;
      s2Valid <= 1'b0;
    end else begin
      s1Valid <= reqValid;
      s2Valid <= s1Valid;
    end
  end

  assign strobe.captureReq = reqValid;
  assign strobe.captureRsp = s1Valid;
  assign strobe.commitKey  = s2Valid;
  assign rspValid          = s2Valid;

  // R4
  rsp_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> ##1 rspValid);
endmodule

// File: rtl/skPrefixKeyUnit.sv
module skPrefixKeyUnit
  import skPkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  parameter int NUM_PAGES = 64,
  parameter int SWAP_BITS = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqKind,
  input  logic              reqWriteOk,
  input  logic [ADDR_W-1:0] prefix,
  output logic              rspValid,
  output logic [ADDR_W-1:0] rspAbsAddr,
  output logic              rspWriteOk,
  output logic              rspPrevRef,
  output logic              rspPrevChg
);
  stageStrobe_t strobe;

  skControl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .strobe  (strobe),
    .rspValid(rspValid)
  );

  skDatapath #(
    .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS),
    .NUM_PAGES(NUM_PAGES), .SWAP_BITS(SWAP_BITS)
  ) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .reqAddr   (reqAddr),
    .reqKind   (reqKind),
    .reqWriteOk(reqWriteOk),
    .prefix    (prefix),
    .rspAbsAddr(rspAbsAddr),
    .rspWriteOk(rspWriteOk),
    .rspPrevRef(rspPrevRef),
    .rspPrevChg(rspPrevChg)
  );
endmodule

// File: tb/tb_skPrefixKeyUnit.sv
module tb_skPrefixKeyUnit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [1:0]  reqKind = '0;
  logic        reqWriteOk = 1'b0;
  logic [31:0] prefix = '0;
  logic        rspValid;
  logic [31:0] rspAbsAddr;
  logic        rspWriteOk, rspPrevRef, rspPrevChg;

  int applied = 0;
  int misses  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  skPrefixKeyUnit dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqKind(reqKind), .reqWriteOk(reqWriteOk), .prefix(prefix),
    .rspValid(rspValid), .rspAbsAddr(rspAbsAddr), .rspWriteOk(rspWriteOk),
    .rspPrevRef(rspPrevRef), .rspPrevChg(rspPrevChg)
  );

  typedef struct packed {
    logic [31:0] pfx;
    logic [31:0] addr;
    logic [1:0]  kind;
    logic        wok;
    logic [31:0] eAbs;
    logic        eWok;
    logic        eRef;
    logic        eChg;
  } vec_t;

  localparam int NV = 15;
  // kind: 0 load, 1 store, 2 fetch
  localparam vec_t VECS [NV] = '{
    '{32'h10000, 32'h00000100, 2'd0, 1'b1, 32'h00010100, 1'b0, 1'b0, 1'b0}, // R1 R5 R10
    '{32'h10000, 32'h00000200, 2'd1, 1'b1, 32'h00010200, 1'b1, 1'b1, 1'b0}, // R6 R7
    '{32'h10000, 32'h00000300, 2'd0, 1'b1, 32'h00010300, 1'b1, 1'b1, 1'b1}, // R5 R6
    '{32'h10000, 32'h00010050, 2'd2, 1'b1, 32'h00000050, 1'b0, 1'b0, 1'b0}, // R2 R5
    '{32'h10000, 32'h00001FFF, 2'd0, 1'b1, 32'h00011FFF, 1'b0, 1'b0, 1'b0}, // R1 edge
    '{32'h10000, 32'h00002000, 2'd0, 1'b1, 32'h00002000, 1'b0, 1'b0, 1'b0}, // R3 edge
    '{32'h10000, 32'h00011FFF, 2'd1, 1'b1, 32'h00001FFF, 1'b1, 1'b0, 1'b0}, // R2 edge
    '{32'h10000, 32'h00012000, 2'd0, 1'b1, 32'h00012000, 1'b0, 1'b0, 1'b0}, // R3 edge
    '{32'h10000, 32'h00050000, 2'd1, 1'b0, 32'h00050000, 1'b0, 1'b0, 1'b0}, // R8
    '{32'h10000, 32'h00050000, 2'd0, 1'b1, 32'h00050000, 1'b1, 1'b0, 1'b0}, // R8
    '{32'h10FFF, 32'h00000100, 2'd0, 1'b1, 32'h00010100, 1'b1, 1'b1, 1'b1}, // R11
    '{32'h20000, 32'h00000100, 2'd0, 1'b1, 32'h00020100, 1'b0, 1'b0, 1'b0}, // R1
    '{32'h20000, 32'h00010100, 2'd0, 1'b1, 32'h00010100, 1'b1, 1'b1, 1'b1}, // R3
    '{32'h20000, 32'h00020010, 2'd0, 1'b1, 32'h00000010, 1'b0, 1'b1, 1'b0}, // R2 R7
    '{32'h20000, 32'h00021000, 2'd2, 1'b0, 32'h00001000, 1'b0, 1'b1, 1'b1}  // R5
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    applied++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] p, input logic [31:0] a,
                       input logic [1:0] k, input logic w);
    reqValid = 1'b1; prefix = p; reqAddr = a; reqKind = k; reqWriteOk = w;
  endtask

  task automatic checkRsp(input string tag, input logic [31:0] eAbs,
                          input logic eWok, input logic eRef, input logic eChg);
    chk({tag, " valid"},   {31'b0, rspValid},   32'd1);
    chk({tag, " abs"},     rspAbsAddr,          eAbs);
    chk({tag, " writeOk"}, {31'b0, rspWriteOk}, {31'b0, eWok});
    chk({tag, " prevRef"}, {31'b0, rspPrevRef}, {31'b0, eRef});
    chk({tag, " prevChg"}, {31'b0, rspPrevChg}, {31'b0, eChg});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset rspValid", {31'b0, rspValid}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R4 idle rspValid", {31'b0, rspValid}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].pfx, VECS[i].addr, VECS[i].kind, VECS[i].wok);
      @(negedge clk);
      reqValid = 1'b0;
      chk($sformatf("R4 vec%0d not early", i), {31'b0, rspValid}, 32'd0);
      @(negedge clk);
      checkRsp($sformatf("R1-3/R5-8/R11 vec%0d", i), VECS[i].eAbs,
               VECS[i].eWok, VECS[i].eRef, VECS[i].eChg);
      @(negedge clk);
      chk($sformatf("R4 vec%0d single pulse", i), {31'b0, rspValid}, 32'd0);
    end

    // R9: store then two loads to page 3 on adjacent cycles
    drive(32'h20000, 32'h00003010, 2'd1, 1'b1);
    @(negedge clk);
    drive(32'h20000, 32'h00003020, 2'd0, 1'b1);
    @(negedge clk);
    drive(32'h20000, 32'h00003030, 2'd0, 1'b1);
    checkRsp("R9 first store", 32'h00003010, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    reqValid = 1'b0;
    checkRsp("R9 second load", 32'h00003020, 1'b1, 1'b1, 1'b1);
    @(negedge clk);
    checkRsp("R9 third load", 32'h00003030, 1'b1, 1'b1, 1'b1);
    @(negedge clk);

    // R9: load then store then load on page 4 (change bit clear first)
    drive(32'h20000, 32'h00004000, 2'd0, 1'b1);
    @(negedge clk);
    drive(32'h20000, 32'h00004004, 2'd1, 1'b1);
    @(negedge clk);
    drive(32'h20000, 32'h00004008, 2'd0, 1'b1);
    checkRsp("R9 load clean", 32'h00004000, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    reqValid = 1'b0;
    checkRsp("R9 store after load", 32'h00004004, 1'b1, 1'b1, 1'b0);
    @(negedge clk);
    checkRsp("R9 load after store", 32'h00004008, 1'b1, 1'b1, 1'b1);
    @(negedge clk);

    // R10: reset clears keys of pages touched above
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R10 rspValid in reset", {31'b0, rspValid}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    drive(32'h10000, 32'h00000100, 2'd0, 1'b1);
    @(negedge clk);
    reqValid = 1'b0;
    @(negedge clk);
    checkRsp("R10 keys cleared", 32'h00010100, 1'b0, 1'b0, 1'b0);
    @(negedge clk);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, misses);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      applied++;
      misses++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", applied, misses);
      $finish;
    end
  end
endmodule